// File: doc/BRIEF.md
# Flagged Eight-Bit ALU with Run-Time Shift Amount

This block is the arithmetic and logic unit of a small multi-cycle processor. It takes two operands and a mode code, and it produces a result at once on a combinational output. It also offers that result through a result register. Two flag registers sit beside the result register. The zero flag is set when the result is zero. The carry flag holds the adder carry-out for add and subtract, and the last bit moved out for shifts and rotates. All three registers capture only on a clock edge where the load strobe is high. Between captures they keep their values, so that a later branch or flag-read step in the processor can still use the flags of the last ALU step.

The operation set covers add, subtract, AND, OR, XOR and complement, plus logical shifts and rotates in both directions. For shifts and rotates, the second operand sets the number of bit positions at run time. Logical shifts clear the result once the amount reaches the data width. Rotates use the amount modulo the width. Operand selection and the register file belong to the surrounding datapath.

Top module: `flag_alu`

## Requirements
- R1: Mode 0 (add) gives a result of (a + b) mod 256. Its carry is the ninth bit of the sum, so 0xFF + 0x01 gives result 0x00 with carry 1.
- R2: Mode 1 (subtract) gives (a - b) mod 256, computed as a + ~b + 1. Its carry is the carry-out of that sum, so carry is 1 exactly when a >= b as unsigned values.
- R3: Mode 2 is AND, mode 3 is OR, mode 5 is XOR, and mode 4 is the complement of a, where b has no effect. All four clear the carry.
- R4: Mode 6 shifts a left by b positions and fills with zeros. The result is 0x00 when b >= 8. The carry is the last bit shifted out, which is a[8-b] for 1 <= b <= 8. The carry is 0 when b = 0 or b > 8.
- R5: Mode 7 shifts a right by b positions and fills with zeros. The result is 0x00 when b >= 8. The carry is a[b-1] for 1 <= b <= 8. The carry is 0 when b = 0 or b > 8.
- R6: Mode 8 rotates a left by (b mod 8) positions, moving the MSB into the LSB on each step. The carry equals result bit 0 when b mod 8 is not 0, and is 0 otherwise.
- R7: Mode 9 rotates a right by (b mod 8) positions, moving the LSB into the MSB on each step. The carry equals result bit 7 when b mod 8 is not 0, and is 0 otherwise.
- R8: After a capture, the registered zero flag is 1 exactly when the registered result is 0x00.
- R9: On a rising clock edge with load high and reset low, the result register takes the combinational result, and both flags take the values belonging to that result. With load low, all three registers hold their values.
- R10: A synchronous active-high reset clears the result register and both flags on the next rising edge, even when load is high.
- R11: The combinational result follows the present operands and mode within the same cycle, with no register on its path.
- R12: Mode codes 10 to 15 give result 0x00 and carry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand, or the shift/rotate amount |
| mode | input | 4 | Operation code |
| load | input | 1 | Capture strobe for the result and flags |
| res_comb | output | 8 | Combinational result |
| res_q | output | 8 | Registered result |
| zero_q | output | 1 | Registered zero flag |
| carry_q | output | 1 | Registered carry flag |

## Verification
Add is driven with a carry-free sum, with sums that wrap to zero and with a plain overflow, so that a wrong carry bit or a missing zero flag shows up on its own. Subtract is driven with a > b, a < b and a = b, which separates the no-borrow convention from an inverted one. Shifts and rotates use amounts 0, 1, mid-range, exactly 8, just above 8 and far above 8. These amounts tell apart a clamped shift from a wrapped one, a modulo rotate from a saturating one, and a correct last-out carry from an off-by-one bit. Directed cases then change the operands while load is low, and assert reset together with load, to show that the flags persist and that reset takes priority.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int DATA_W = 8;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_NOT = 4'd4,
        OP_XOR = 4'd5,
        OP_SHL = 4'd6,
        OP_SHR = 4'd7,
        OP_ROL = 4'd8,
        OP_ROR = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2,
        BW_NOT = 2'd3
    } bw_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        cout  = wide[W];
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import flag_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  bw_sel_e      sel,
    output logic [W-1:0] res
);

    always_comb begin
        unique case (sel)
            BW_AND: res = a & b;
            BW_OR:  res = a | b;
            BW_XOR: res = a ^ b;
            BW_NOT: res = ~a;
        endcase
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] amt,
    input  logic         left,
    input  logic         rotate,
    output logic [W-1:0] res,
    output logic         cout
);

    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] rot_amt;
    logic [W-1:0]    rl [SH_W+1];
    logic [W-1:0]    rr [SH_W+1];
    logic [2*W-1:0]  ext_l;
    logic [2*W-1:0]  ext_r;

    assign rot_amt = amt[SH_W-1:0];
    assign rl[0]   = a;
    assign rr[0]   = a;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int S = 2 ** i;
        assign rl[i+1] = rot_amt[i] ? {rl[i][W-1-S:0], rl[i][W-1:W-S]} : rl[i];
        assign rr[i+1] = rot_amt[i] ? {rr[i][S-1:0], rr[i][W-1:S]} : rr[i];
    end

    always_comb begin
        ext_l = {{W{1'b0}}, a} << amt;
        ext_r = {a, {W{1'b0}}} >> amt;
        if (rotate) begin
            if (left) begin
                res  = rl[SH_W];
                cout = (rot_amt != '0) && rl[SH_W][0];
            end else begin
                res  = rr[SH_W];
                cout = (rot_amt != '0) && rr[SH_W][W-1];
            end
        end else if (left) begin
            res  = ext_l[W-1:0];
            cout = ext_l[W];
        end else begin
            res  = ext_r[2*W-1:W];
            cout = ext_r[W-1];
        end
    end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [MODE_W-1:0] mode,
    input  logic              load,
    output logic [W-1:0]      res_comb,
    output logic [W-1:0]      res_q,
    output logic              zero_q,
    output logic              carry_q
);

    alu_op_e      op;
    logic [W-1:0] as_sum;
    logic         as_cout;
    logic [W-1:0] bw_res;
    bw_sel_e      bw_sel;
    logic [W-1:0] sh_res;
    logic         sh_cout;
    logic         carry_nxt;

    assign op = alu_op_e'(mode);

    always_comb begin
        unique case (op)
            OP_OR:   bw_sel = BW_OR;
            OP_XOR:  bw_sel = BW_XOR;
            OP_NOT:  bw_sel = BW_NOT;
            default: bw_sel = BW_AND;
        endcase
    end

    alu_addsub #(.W(W)) addsub_i (
        .a    (op_a),
        .b    (op_b),
        .sub  (op == OP_SUB),
        .sum  (as_sum),
        .cout (as_cout)
    );

    alu_bitwise #(.W(W)) bitwise_i (
        .a   (op_a),
        .b   (op_b),
        .sel (bw_sel),
        .res (bw_res)
    );

    alu_shifter #(.W(W)) shifter_i (
        .a      (op_a),
        .amt    (op_b),
        .left   ((op == OP_SHL) || (op == OP_ROL)),
        .rotate ((op == OP_ROL) || (op == OP_ROR)),
        .res    (sh_res),
        .cout   (sh_cout)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: begin
                res_comb  = as_sum;
                carry_nxt = as_cout;
            end
            OP_AND, OP_OR, OP_NOT, OP_XOR: begin
                res_comb  = bw_res;
                carry_nxt = 1'b0;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                res_comb  = sh_res;
                carry_nxt = sh_cout;
            end
            default: begin
                res_comb  = '0;
                carry_nxt = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            zero_q  <= 1'b0;
            carry_q <= 1'b0;
        end else if (load) begin
            res_q   <= res_comb;
            zero_q  <= (res_comb == '0);
            carry_q <= carry_nxt;
        end
    end

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
    import flag_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [W-1:0]      op_a,
    input logic [W-1:0]      op_b,
    input logic [MODE_W-1:0] mode,
    input logic              load,
    input logic [W-1:0]      res_comb,
    input logic [W-1:0]      res_q,
    input logic              zero_q,
    input logic              carry_q
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(res_q) && $stable(zero_q) && $stable(carry_q))); // R9
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load |=> (res_q == $past(res_comb))); // R9
    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
        load |=> (zero_q == (res_q == '0))); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (res_q == '0 && !zero_q && !carry_q)); // R10
    AST_SUB_CARRY: assert property (@(posedge clk) disable iff (rst)
        (load && mode == OP_SUB) |=> (carry_q == ($past(op_a) >= $past(op_b)))); // R2
    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (load && (mode == OP_AND || mode == OP_OR || mode == OP_XOR || mode == OP_NOT)) |=> !carry_q); // R3
    AST_UNUSED_MODE: assert property (@(posedge clk) disable iff (rst)
        (mode > OP_ROR) |-> (res_comb == '0)); // R12

endmodule

bind flag_alu flag_alu_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .op_a     (op_a),
    .op_b     (op_b),
    .mode     (mode),
    .load     (load),
    .res_comb (res_comb),
    .res_q    (res_q),
    .zero_q   (zero_q),
    .carry_q  (carry_q)
);

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;

    localparam int NV = 30;
    localparam int WATCHDOG_NS = 40000;

    // {requirement, mode, a, b, expected result, expected carry}
    localparam logic [32:0] VEC [NV] = '{
        {4'd1,  4'd0, 8'h12, 8'h34, 8'h46, 1'b0}, // R1 plain add
        {4'd1,  4'd0, 8'hFF, 8'h01, 8'h00, 1'b1}, // R1 wrap to zero
        {4'd1,  4'd0, 8'h80, 8'h80, 8'h00, 1'b1}, // R1
        {4'd1,  4'd0, 8'hF0, 8'h20, 8'h10, 1'b1}, // R1
        {4'd2,  4'd1, 8'h50, 8'h20, 8'h30, 1'b1}, // R2 a > b
        {4'd2,  4'd1, 8'h20, 8'h50, 8'hD0, 1'b0}, // R2 a < b
        {4'd2,  4'd1, 8'h33, 8'h33, 8'h00, 1'b1}, // R2 a = b
        {4'd3,  4'd2, 8'hF0, 8'h3C, 8'h30, 1'b0}, // R3 AND
        {4'd3,  4'd3, 8'hF0, 8'h0C, 8'hFC, 1'b0}, // R3 OR
        {4'd3,  4'd5, 8'hFF, 8'h0F, 8'hF0, 1'b0}, // R3 XOR
        {4'd3,  4'd4, 8'h5A, 8'hFF, 8'hA5, 1'b0}, // R3 NOT, b = FF
        {4'd3,  4'd4, 8'h5A, 8'h00, 8'hA5, 1'b0}, // R3 NOT, b = 00
        {4'd4,  4'd6, 8'h0E, 8'h04, 8'hE0, 1'b0}, // R4
        {4'd4,  4'd6, 8'h81, 8'h01, 8'h02, 1'b1}, // R4
        {4'd4,  4'd6, 8'h0F, 8'h00, 8'h0F, 1'b0}, // R4 amount 0
        {4'd4,  4'd6, 8'hFF, 8'h08, 8'h00, 1'b1}, // R4 amount 8
        {4'd4,  4'd6, 8'hFF, 8'h09, 8'h00, 1'b0}, // R4 amount 9
        {4'd5,  4'd7, 8'h81, 8'h01, 8'h40, 1'b1}, // R5
        {4'd5,  4'd7, 8'hB4, 8'h03, 8'h16, 1'b1}, // R5
        {4'd5,  4'd7, 8'h80, 8'h08, 8'h00, 1'b1}, // R5 amount 8
        {4'd5,  4'd7, 8'h80, 8'hC8, 8'h00, 1'b0}, // R5 amount 200
        {4'd6,  4'd8, 8'h81, 8'h01, 8'h03, 1'b1}, // R6
        {4'd6,  4'd8, 8'h96, 8'h04, 8'h69, 1'b1}, // R6
        {4'd6,  4'd8, 8'h96, 8'h08, 8'h96, 1'b0}, // R6 amount 8 wraps to 0
        {4'd6,  4'd8, 8'h01, 8'h09, 8'h02, 1'b0}, // R6 amount 9
        {4'd7,  4'd9, 8'h81, 8'h01, 8'hC0, 1'b1}, // R7
        {4'd7,  4'd9, 8'h01, 8'h03, 8'h20, 1'b0}, // R7
        {4'd7,  4'd9, 8'h2C, 8'h0A, 8'h0B, 1'b0}, // R7 amount 10
        {4'd12, 4'd10, 8'hFF, 8'hFF, 8'h00, 1'b0}, // R12
        {4'd12, 4'd15, 8'h7E, 8'h01, 8'h00, 1'b0}  // R12
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] op_a;
    logic [7:0] op_b;
    logic [3:0] mode;
    logic       load;
    logic [7:0] res_comb;
    logic [7:0] res_q;
    logic       zero_q;
    logic       carry_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flag_alu dut_i (
        .clk      (clk),
        .rst      (rst),
        .op_a     (op_a),
        .op_b     (op_b),
        .mode     (mode),
        .load     (load),
        .res_comb (res_comb),
        .res_q    (res_q),
        .zero_q   (zero_q),
        .carry_q  (carry_q)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req, input logic [7:0] er,
                              input logic ez, input logic ec);
        check(res_q == er, req, "res_q", res_q, er);
        check(zero_q == ez, req, "zero_q", zero_q, ez);
        check(carry_q == ec, req, "carry_q", carry_q, ec);
    endtask

    initial begin
        #(WATCHDOG_NS);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst  = 1'b1;
        load = 1'b1;
        op_a = 8'hFF;
        op_b = 8'h01;
        mode = 4'd0;
        repeat (3) @(negedge clk);
        check_regs("R10", 8'h00, 1'b0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string rq;
            logic [7:0] er;
            logic ec;
            rq   = $sformatf("R%0d", VEC[i][32:29]);
            mode = VEC[i][28:25];
            op_a = VEC[i][24:17];
            op_b = VEC[i][16:9];
            er   = VEC[i][8:1];
            ec   = VEC[i][0];
            load = 1'b1;
            #1;
            check(res_comb == er, {rq, "/R11"}, "res_comb", res_comb, er);
            @(negedge clk);
            check_regs({rq, "/R8"}, er, (er == 8'h00), ec);
        end

        // R9: capture a zero result with carry set, then change inputs with load low
        mode = 4'd0; op_a = 8'hFF; op_b = 8'h01; load = 1'b1;
        @(negedge clk);
        check_regs("R9", 8'h00, 1'b1, 1'b1);
        load = 1'b0; mode = 4'd2; op_a = 8'h12; op_b = 8'h34;
        #1;
        check(res_comb == 8'h10, "R11", "res_comb", res_comb, 8'h10);
        repeat (3) @(negedge clk);
        check_regs("R9", 8'h00, 1'b1, 1'b1);
        load = 1'b1;
        @(negedge clk);
        check_regs("R9", 8'h10, 1'b0, 1'b0);

        // R10: reset wins over load
        mode = 4'd0; op_a = 8'hF0; op_b = 8'h20; load = 1'b1; rst = 1'b1;
        @(negedge clk);
        check_regs("R10", 8'h00, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_regs("R9", 8'h10, 1'b0, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule